// File: doc/BRIEF.md
# Paced Sound-Chip Write Bridge

This block connects a CPU's I/O write bus to a sound synthesizer whose register interface loses any write that comes too soon after the one before it. It answers four consecutive I/O port addresses. These form two register banks, and each bank has a register-address port and a register-data port. Every write to one of these ports goes into a small queue. The block then replays the queued writes to the synthesizer's bus one at a time. After each replayed write it waits a recovery time measured in synthesizer clock cycles, and that time depends on whether the write was an address write or a data write.

The CPU can write at full speed. It never needs counted delay loops. When the queue is full, a wait request holds the CPU bus cycle until a slot frees up, and no write is discarded. Software that prefers to poll can read a busy flag. The flag is set while queued writes remain or a recovery time is still running.

All logic runs on one system clock. The synthesizer clock is supplied as a one-cycle enable pulse, `chip_ce`. Reset is synchronous and active high.

Top module: `paced_synth_bridge`

## Requirements
- R1: A write with `io_addr` in 4..7 is forwarded to the synthesizer bus with `chip_sel = io_addr[1:0]` (bit 0: 0 = register address, 1 = register data; bit 1: 0 = bank A, 1 = bank B) and `chip_data = io_wdata`. A write to any other address produces no synthesizer strobe.
- R2: Forwarded writes reach the synthesizer bus in the order the CPU issued them, with none lost or duplicated.
- R3: After a strobe whose `chip_sel[0]` is 0, at least 17 `chip_ce` cycles pass strictly between that strobe's enable cycle and the next strobe's enable cycle.
- R4: After a strobe whose `chip_sel[0]` is 1, at least 83 `chip_ce` cycles pass strictly between that strobe's enable cycle and the next strobe's enable cycle.
- R5: `chip_wr` stays high for exactly one cycle in which `chip_ce` is high. `chip_sel` and `chip_data` do not change while `chip_wr` is high.
- R6: The queue holds 8 writes. A decoded write that arrives while the queue is full raises `io_wait` in the same cycle and is accepted only once `io_wait` falls. `io_wait` is never high for a write that is not decoded.
- R7: A read (`io_rd`) from port 4 or 6 returns 0x80 while busy and 0x00 otherwise. Busy means the queue is non-empty, a recovery time is still running, or a strobe is pending.
- R8: A read from port 5, port 7, or any address outside 4..7 returns 0x00.
- R9: Synchronous reset empties the queue, clears the recovery timer and drops `chip_wr`. After reset the status reads 0x00 and no queued write is replayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_ce | input | 1 | Synthesizer clock enable, one system cycle per synthesizer clock |
| io_addr | input | 8 | CPU I/O port address |
| io_wdata | input | 8 | CPU write data |
| io_wr | input | 1 | CPU I/O write request, held while `io_wait` is high |
| io_rd | input | 1 | CPU I/O read request |
| io_rdata | output | 8 | Status byte for status reads, zero otherwise |
| io_wait | output | 1 | Wait request: queue full for a decoded write |
| chip_sel | output | 2 | Register-select lines to the synthesizer |
| chip_data | output | 8 | Data bus to the synthesizer |
| chip_wr | output | 1 | Write strobe to the synthesizer |

## Verification
The assertions assume three things about the inputs. `chip_ce` is a single-cycle pulse that never stays high on two cycles in a row. A CPU that sees `io_wait` keeps `io_wr`, `io_addr` and `io_wdata` unchanged until the wait clears. `io_wr` and `io_rd` are never high together. The bench produces `chip_ce` as one pulse every third clock. Its write task holds the whole request until `io_wait` is low, and its reads and writes run in separate tasks that never overlap. The recovery-gap assertions count enable cycles in a counter inside the checker, so they rely only on `chip_ce` behaving as a pulse.

// File: rtl/psb_pkg.sv
package psb_pkg;
  // Position of the address/data choice inside the register select.
  localparam int SEL_KIND_BIT = 0;
  // Position of the bank choice inside the register select.
  localparam int SEL_BANK_BIT = 1;

  // Recovery time in synthesizer clocks owed after a write of the given kind.
  function automatic int unsigned gap_for(input logic is_data,
                                          input int unsigned gap_addr,
                                          input int unsigned gap_data);
    return is_data ? gap_data : gap_addr;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/psb_portdec.sv
module psb_portdec #(
  parameter int AW        = 8,
  parameter int PORT_BASE = 4
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  output logic          wr_hit,
  output logic          stat_hit,
  output logic [1:0]    sel
);
  import psb_pkg::*;
  localparam logic [AW-1:0] BASE = AW'(PORT_BASE);

  logic window;
  assign window   = (addr[AW-1:2] == BASE[AW-1:2]);
  assign sel      = addr[1:0];
  assign wr_hit   = wr & window;
  assign stat_hit = rd & window & ~addr[SEL_KIND_BIT];
endmodule

// File: rtl/psb_fifo.sv
module psb_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CNTW-1:0] cnt;
  logic            do_push, do_pop;

  assign full    = (cnt == CNTW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/psb_pacer.sv
module psb_pacer #(
  parameter int DW       = 8,
  parameter int GAP_ADDR = 17,
  parameter int GAP_DATA = 83
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          avail,
  input  logic [1:0]    head_sel,
  input  logic [DW-1:0] head_data,
  output logic          issue,
  output logic          gap_zero,
  output logic          chip_wr,
  output logic [1:0]    chip_sel,
  output logic [DW-1:0] chip_data
);
  import psb_pkg::*;
  localparam int GMAX = max_of(GAP_ADDR, GAP_DATA);
  localparam int CW   = $clog2(GMAX + 1);

  logic [CW-1:0] gap_q;

  assign gap_zero = (gap_q == '0);
  assign issue    = ce & avail & gap_zero & ~chip_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q     <= '0;
      chip_wr   <= 1'b0;
      chip_sel  <= '0;
      chip_data <= '0;
    end else if (issue) begin
      gap_q     <= CW'(gap_for(head_sel[SEL_KIND_BIT], GAP_ADDR, GAP_DATA));
      chip_wr   <= 1'b1;
      chip_sel  <= head_sel;
      chip_data <= head_data;
    end else if (ce) begin
      chip_wr <= 1'b0;
      if (!gap_zero) gap_q <= gap_q - 1'b1;
    end
  end
endmodule

// File: rtl/paced_synth_bridge.sv
module paced_synth_bridge #(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int PORT_BASE  = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int GAP_ADDR   = 17,
  parameter int GAP_DATA   = 83
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_ce,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic          io_wr,
  input  logic          io_rd,
  output logic [DW-1:0] io_rdata,
  output logic          io_wait,
  output logic [1:0]    chip_sel,
  output logic [DW-1:0] chip_data,
  output logic          chip_wr
);
  localparam int EW = DW + 2;

  logic          wr_hit, stat_hit;
  logic [1:0]    dec_sel;
  logic          fifo_full, fifo_empty;
  logic          push_evt, issue_evt, gap_zero, busy;
  logic [EW-1:0] head;

  psb_portdec #(.AW(AW), .PORT_BASE(PORT_BASE)) u_dec (
    .addr(io_addr), .wr(io_wr), .rd(io_rd),
    .wr_hit(wr_hit), .stat_hit(stat_hit), .sel(dec_sel)
  );

  assign push_evt = wr_hit & ~fifo_full;
  assign io_wait  = wr_hit & fifo_full;

  psb_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push_evt), .pop(issue_evt),
    .din({dec_sel, io_wdata}), .dout(head),
    .full(fifo_full), .empty(fifo_empty)
  );

  psb_pacer #(.DW(DW), .GAP_ADDR(GAP_ADDR), .GAP_DATA(GAP_DATA)) u_pace (
    .clk(clk), .rst(rst), .ce(chip_ce), .avail(~fifo_empty),
    .head_sel(head[EW-1 -: 2]), .head_data(head[DW-1:0]),
    .issue(issue_evt), .gap_zero(gap_zero),
    .chip_wr(chip_wr), .chip_sel(chip_sel), .chip_data(chip_data)
  );

  assign busy     = ~fifo_empty | ~gap_zero | chip_wr;
  assign io_rdata = stat_hit ? {busy, {(DW-1){1'b0}}} : '0;
endmodule

// File: rtl/psb_checker.sv
module psb_checker #(
  parameter int DW       = 8,
  parameter int GAP_ADDR = 17,
  parameter int GAP_DATA = 83
) (
  input logic          clk,
  input logic          rst,
  input logic          chip_ce,
  input logic          io_wr,
  input logic          io_wait,
  input logic [DW-1:0] io_rdata,
  input logic          stat_hit,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic          issue_evt,
  input logic          chip_wr,
  input logic [1:0]    chip_sel,
  input logic [DW-1:0] chip_data
);
  logic [15:0] since;
  logic        seen, prev_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      since     <= '0;
      seen      <= 1'b0;
      prev_data <= 1'b0;
    end else if (chip_ce) begin
      if (chip_wr) begin
        since     <= '0;
        seen      <= 1'b1;
        prev_data <= chip_sel[0];
      end else if (since != 16'hFFFF) begin
        since <= since + 1'b1;
      end
    end
  end

  assert_strobe_single_ce_R5: assert property (@(posedge clk) disable iff (rst)
    (chip_wr && chip_ce) |=> !chip_wr);
  assert_strobe_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (chip_wr && !chip_ce) |=> ($stable(chip_sel) && $stable(chip_data)));
  assert_addr_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (chip_ce && chip_wr && seen && !prev_data) |-> (since >= 16'(GAP_ADDR)));
  assert_data_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (chip_ce && chip_wr && seen && prev_data) |-> (since >= 16'(GAP_DATA)));
  assert_wait_when_full_R6: assert property (@(posedge clk) disable iff (rst)
    io_wait |-> (fifo_full && io_wr));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !issue_evt) |=> !fifo_empty);
  assert_status_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_hit && !fifo_empty) |-> io_rdata[DW-1]);
  assert_reset_clean_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!chip_wr && fifo_empty));
endmodule

bind paced_synth_bridge psb_checker #(.DW(DW), .GAP_ADDR(GAP_ADDR), .GAP_DATA(GAP_DATA)) u_chk (
  .clk(clk), .rst(rst), .chip_ce(chip_ce), .io_wr(io_wr), .io_wait(io_wait),
  .io_rdata(io_rdata), .stat_hit(stat_hit), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .issue_evt(issue_evt), .chip_wr(chip_wr),
  .chip_sel(chip_sel), .chip_data(chip_data)
);

// File: tb/test_paced_synth_bridge.sv
module test_paced_synth_bridge;
  localparam int GA = 17;
  localparam int GD = 83;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chip_ce = 1'b0;
  logic [7:0] io_addr = '0, io_wdata = '0, io_rdata;
  logic       io_wr = 1'b0, io_rd = 1'b0, io_wait;
  logic [1:0] chip_sel;
  logic [7:0] chip_data;
  logic       chip_wr;

  paced_synth_bridge i_paced_synth_bridge (
    .clk(clk), .rst(rst), .chip_ce(chip_ce), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_wait(io_wait),
    .chip_sel(chip_sel), .chip_data(chip_data), .chip_wr(chip_wr)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0, waits = 0, strobes = 0;
  int ce_idx = 0, ce_phase = 0, last_n = 0, pulse_ce = 0;
  bit have_last = 0, prev_wr = 0, flushing = 0, finished = 0;
  logic [1:0] last_sel, prev_sel;
  logic [7:0] prev_data;
  logic [9:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor and enable generator, all away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (!flushing && !rst) begin
      if (prev_wr && chip_wr) begin   // R5 stability while the strobe is high
        chip_check_stable();
      end
      if (prev_wr && !chip_wr) chk(pulse_ce == 1, "R5 strobe enable count", pulse_ce, 1);
      if (chip_wr && chip_ce) begin
        strobes++;
        pulse_ce++;
        if (exp_q.size() == 0) chk(0, "R1 unexpected strobe", {chip_sel, chip_data}, -1);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk({chip_sel, chip_data} == e, "R2 order and R1 select/data", {chip_sel, chip_data}, e);
        end
        if (have_last) begin
          int need;
          need = last_sel[0] ? GD : GA;
          if (last_sel[0]) chk(ce_idx - last_n >= need + 1, "R4 data gap", ce_idx - last_n, need + 1);
          else             chk(ce_idx - last_n >= need + 1, "R3 address gap", ce_idx - last_n, need + 1);
        end
        have_last = 1;
        last_n    = ce_idx;
        last_sel  = chip_sel;
      end
      if (!chip_wr) pulse_ce = 0;
    end
    prev_wr   = chip_wr;
    prev_sel  = chip_sel;
    prev_data = chip_data;
    if (chip_ce) ce_idx++;
    ce_phase = (ce_phase == 2) ? 0 : ce_phase + 1;
    chip_ce  = (ce_phase == 0);
    if (cycles > 150000 && !finished) begin
      finished = 1;
      chk(0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  task automatic chip_check_stable();
    chk(chip_sel == prev_sel && chip_data == prev_data, "R5 held values",
        {chip_sel, chip_data}, {prev_sel, prev_data});
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    forever begin
      #1;
      if (!io_wait) break;
      waits++;
      @(negedge clk);
    end
    if (a[7:2] == 6'd1) exp_q.push_back({a[1:0], d});
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [7:0] a, output logic [7:0] v);
    io_addr = a; io_rd = 1'b1;
    #1 v = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (3 * (GD + 4)) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    int s0, w0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(chip_wr == 0, "R9 strobe after reset", chip_wr, 0);
    #1 chk(io_wait == 0, "R9 wait after reset", io_wait, 0);
    cpu_read(8'd4, v); chk(v == 8'h00, "R9 status after reset", v, 0);

    // R1 each port once, R3/R4 gaps, R7/R8 status while busy
    cpu_write(8'd4, 8'h22);
    cpu_write(8'd5, 8'h5A);
    cpu_write(8'd6, 8'h31);
    cpu_write(8'd7, 8'hC3);
    cpu_read(8'd4, v); chk(v == 8'h80, "R7 busy on bank A address port", v, 8'h80);
    cpu_read(8'd6, v); chk(v == 8'h80, "R7 busy on bank B address port", v, 8'h80);
    cpu_read(8'd5, v); chk(v == 8'h00, "R8 data port read", v, 0);
    cpu_read(8'd7, v); chk(v == 8'h00, "R8 data port read", v, 0);
    drain();
    cpu_read(8'd4, v); chk(v == 8'h00, "R7 idle status", v, 0);
    cpu_read(8'd6, v); chk(v == 8'h00, "R7 idle status", v, 0);

    // R6 burst past the queue depth, nothing dropped (R2 via monitor)
    waits = 0;
    for (int i = 0; i < 12; i++) cpu_write(8'd4 + 8'(i % 4), 8'(8'h10 + i));
    chk(waits > 0, "R6 wait raised on full queue", waits, 1);
    drain();
    chk(exp_q.size() == 0, "R6 burst fully delivered", exp_q.size(), 0);

    // R1 address sweep: only 4..7 produce strobes; R6 no wait on others
    s0 = strobes; w0 = waits;
    for (int a = 0; a < 256; a++) cpu_write(8'(a), 8'(a) ^ 8'hA5);
    drain();
    chk(strobes - s0 == 4, "R1 decoded strobe count", strobes - s0, 4);
    chk(exp_q.size() == 0, "R1 sweep delivered", exp_q.size(), 0);
    chk(waits == w0, "R6 no wait in sweep", waits - w0, 0);

    // R7/R8 read sweep while busy with queued data writes
    for (int i = 0; i < 4; i++) cpu_write(8'd5, 8'(i));
    for (int a = 0; a < 256; a++) begin
      logic [7:0] e;
      e = (a == 4 || a == 6) ? 8'h80 : 8'h00;
      cpu_read(8'(a), v);
      if (a == 4 || a == 6) chk(v == e, "R7 busy read sweep", v, e);
      else                  chk(v == e, "R8 non-status read sweep", v, e);
    end
    drain();
    for (int a = 0; a < 256; a++) begin
      cpu_read(8'(a), v);
      chk(v == 8'h00, "R7 idle read sweep", v, 0);
    end

    // R9 reset while writes are queued: none replayed afterwards
    for (int i = 0; i < 5; i++) cpu_write(8'd7, 8'(8'h40 + i));
    flushing = 1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    have_last = 0;
    @(negedge clk);
    flushing = 0;
    chk(chip_wr == 0, "R9 strobe cleared", chip_wr, 0);
    cpu_read(8'd4, v); chk(v == 8'h00, "R9 status cleared", v, 0);
    s0 = strobes;
    repeat (600) @(negedge clk);
    chk(strobes == s0, "R9 no replay after reset", strobes - s0, 0);

    // R3/R4 once more after reset: address then data on bank B
    cpu_write(8'd6, 8'h77);
    cpu_write(8'd7, 8'h88);
    cpu_write(8'd6, 8'h99);
    drain();
    chk(exp_q.size() == 0, "R2 post-reset writes delivered", exp_q.size(), 0);

    finished = 1;
    finish_run();
  end
endmodule